// File: doc/BRIEF.md
# Power-of-Two Sample Averager

This block sits between an analog-to-digital converter and the per-sequence result storage. It sums a run of 2^k conversions that belong to one step (same channel and same sequence tag) and hands on a single result: the sum shifted right by k. The shift k comes from a 3-bit configuration input. A shift of 0 turns averaging off, and each sample then goes straight through. Shifts 1 to 6 give ratios of 2 to 64. One setting covers every sequence.

Each result that leaves the block is already a full average. Downstream storage therefore keeps its normal number of entries per sequence. Only the result rate drops, by the averaging ratio. While a run is partly summed, the block raises a repeat request so that the scheduler converts the same step again.

The block reads the shift setting when a run starts and holds it for the whole run. A sample whose tag differs from the run in progress abandons the partial sum and starts a new run with that sample.

Top module: `sample_averager`

## Requirements
- R1: After reset, `res_valid` and `repeat_step` are both low.
- R2: With shift 0, each accepted sample appears on `res_sample` with `res_valid` high one clock after its `smp_valid` cycle. Its tag is unchanged and `repeat_step` stays low.
- R3: With shift k from 1 to 6, after 2^k accepted samples with one tag, `res_valid` pulses for one clock, one cycle after the last sample. `res_sample` is then floor(sum / 2^k), and no result comes out for the earlier samples of the run.
- R4: The sum never wraps. Sixty-four samples of 4095 at shift 6 give 4095.
- R5: A shift setting of 7 behaves as 6, so a run is 64 samples long.
- R6: The block samples the shift setting on the first sample of a run. A change during the run affects only the next run.
- R7: A sample whose channel or sequence tag differs from the run in progress drops the partial sum. That sample becomes the first of a new run.
- R8: From the cycle after the first sample of a multi-sample run until its result appears, `repeat_step` is high. It is low in the cycle where `res_valid` is high.
- R9: `res_chan` and `res_seq` carry the tag of the samples that were averaged.
- R10: Cycles with `smp_valid` low add nothing to the run and leave it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| avg_shift | input | 3 | Averaging shift k; 0 is pass-through, 7 acts as 6 |
| smp_valid | input | 1 | A raw sample is present this cycle |
| smp_data | input | 12 | Raw conversion result |
| smp_chan | input | 4 | Input channel tag of the sample |
| smp_seq | input | 2 | Sequence tag of the sample |
| res_valid | output | 1 | One-cycle strobe for an averaged result |
| res_sample | output | 12 | Averaged result |
| res_chan | output | 4 | Channel tag of the result |
| res_seq | output | 2 | Sequence tag of the result |
| repeat_step | output | 1 | Asks the scheduler to convert the current step again |

## Verification
The bench builds the block with its defaults: 12-bit samples, a largest shift of 6 and an 18-bit sum. This puts the full 64-sample run, the full-scale no-wrap case and the shift-7 saturation within reach of one short run. The 4-bit channel and 2-bit sequence tags leave room for tag switches in the middle of a run. A behavioural model runs alongside the block and is compared on every clock. Random shift changes, idle gaps and tag switches then reach the setting-latch and restart orderings, which the directed cases alone do not combine.

// File: rtl/avg_pkg.sv
package avg_pkg;

  // Saturate a requested shift to the largest supported value.
  function automatic int unsigned sat_shift(input int unsigned raw,
                                            input int unsigned lim);
    return (raw > lim) ? lim : raw;
  endfunction

endpackage

// File: rtl/avg_ctrl.sv
module avg_ctrl
  import avg_pkg::*;
#(
  parameter int SHIFT_W   = 3,
  parameter int MAX_SHIFT = 6,
  parameter int CHAN_W    = 4,
  parameter int SEQ_W     = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SHIFT_W-1:0] shift_cfg,
  input  logic               in_valid,
  input  logic [CHAN_W-1:0]  in_chan,
  input  logic [SEQ_W-1:0]   in_seq,
  output logic               start,
  output logic               done,
  output logic [SHIFT_W-1:0] eff_shift,
  output logic               busy
);
  localparam int CNT_W = MAX_SHIFT + 1;

  logic               busy_q, busy_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_inc, target;
  logic [SHIFT_W-1:0] shift_q, shift_d;
  logic [CHAN_W-1:0]  chan_q, chan_d;
  logic [SEQ_W-1:0]   seq_q, seq_d;
  logic               tag_hit;

  always_comb begin
    tag_hit   = busy_q && (in_chan == chan_q) && (in_seq == seq_q);
    start     = in_valid && !tag_hit;
    eff_shift = start ? SHIFT_W'(sat_shift(int'(shift_cfg), MAX_SHIFT)) : shift_q;
    cnt_inc   = start ? CNT_W'(1) : cnt_q + CNT_W'(1);
    target    = CNT_W'(1) << eff_shift;
    done      = in_valid && (cnt_inc == target);

    busy_d  = busy_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    chan_d  = chan_q;
    seq_d   = seq_q;
    if (in_valid) begin
      busy_d = !done;
      cnt_d  = cnt_inc;
      if (start) begin
        shift_d = eff_shift;
        chan_d  = in_chan;
        seq_d   = in_seq;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      shift_q <= '0;
      chan_q  <= '0;
      seq_q   <= '0;
    end else if (in_valid) begin
      busy_q  <= busy_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      chan_q  <= chan_d;
      seq_q   <= seq_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/avg_datapath.sv
module avg_datapath #(
  parameter int SAMPLE_W  = 12,
  parameter int SHIFT_W   = 3,
  parameter int MAX_SHIFT = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                start,
  input  logic                done,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [SHIFT_W-1:0]  eff_shift,
  output logic [SAMPLE_W-1:0] avg_result
);
  localparam int ACC_W = SAMPLE_W + MAX_SHIFT;

  logic [ACC_W-1:0]    acc_q, acc_d, sum;
  logic [SAMPLE_W-1:0] cand [0:MAX_SHIFT];

  assign sum = (start ? '0 : acc_q) + ACC_W'(in_sample);

  for (genvar s = 0; s <= MAX_SHIFT; s++) begin : g_shift
    assign cand[s] = SAMPLE_W'(sum >> s);
  end

  always_comb begin
    avg_result = '0;
    for (int s = 0; s <= MAX_SHIFT; s++) begin
      if (eff_shift == SHIFT_W'(s)) avg_result = cand[s];
    end
  end

  always_comb begin
    acc_d = done ? '0 : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (in_valid) acc_q <= acc_d;
  end

endmodule

// File: rtl/avg_out_stage.sv
module avg_out_stage #(
  parameter int SAMPLE_W = 12,
  parameter int CHAN_W   = 4,
  parameter int SEQ_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                done,
  input  logic [SAMPLE_W-1:0] avg_result,
  input  logic [CHAN_W-1:0]   in_chan,
  input  logic [SEQ_W-1:0]    in_seq,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic [CHAN_W-1:0]   out_chan,
  output logic [SEQ_W-1:0]    out_seq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sample <= '0;
      out_chan   <= '0;
      out_seq    <= '0;
    end else if (done) begin
      out_sample <= avg_result;
      out_chan   <= in_chan;
      out_seq    <= in_seq;
    end
  end

endmodule

// File: rtl/sample_averager.sv
module sample_averager #(
  parameter int SAMPLE_W  = 12,
  parameter int SHIFT_W   = 3,
  parameter int MAX_SHIFT = 6,
  parameter int CHAN_W    = 4,
  parameter int SEQ_W     = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SHIFT_W-1:0]  avg_shift,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [CHAN_W-1:0]   smp_chan,
  input  logic [SEQ_W-1:0]    smp_seq,
  output logic                res_valid,
  output logic [SAMPLE_W-1:0] res_sample,
  output logic [CHAN_W-1:0]   res_chan,
  output logic [SEQ_W-1:0]    res_seq,
  output logic                repeat_step
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic                start, done;
  logic [SHIFT_W-1:0]  eff_shift;
  logic [SAMPLE_W-1:0] avg_result;

  // Assert asynchronously, release on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  avg_ctrl #(
    .SHIFT_W(SHIFT_W), .MAX_SHIFT(MAX_SHIFT), .CHAN_W(CHAN_W), .SEQ_W(SEQ_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .shift_cfg(avg_shift), .in_valid(smp_valid),
    .in_chan(smp_chan), .in_seq(smp_seq), .start(start), .done(done),
    .eff_shift(eff_shift), .busy(repeat_step)
  );

  avg_datapath #(
    .SAMPLE_W(SAMPLE_W), .SHIFT_W(SHIFT_W), .MAX_SHIFT(MAX_SHIFT)
  ) u_dp (
    .clk(clk), .rst_n(rst_int_n), .in_valid(smp_valid), .start(start),
    .done(done), .in_sample(smp_data), .eff_shift(eff_shift),
    .avg_result(avg_result)
  );

  avg_out_stage #(
    .SAMPLE_W(SAMPLE_W), .CHAN_W(CHAN_W), .SEQ_W(SEQ_W)
  ) u_out (
    .clk(clk), .rst_n(rst_int_n), .done(done), .avg_result(avg_result),
    .in_chan(smp_chan), .in_seq(smp_seq), .out_valid(res_valid),
    .out_sample(res_sample), .out_chan(res_chan), .out_seq(res_seq)
  );

endmodule

// File: rtl/sample_averager_chk.sv
module sample_averager_chk #(
  parameter int SAMPLE_W = 12,
  parameter int SHIFT_W  = 3,
  parameter int CHAN_W   = 4,
  parameter int SEQ_W    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SHIFT_W-1:0]  avg_shift,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic [CHAN_W-1:0]   smp_chan,
  input logic [SEQ_W-1:0]    smp_seq,
  input logic                res_valid,
  input logic [SAMPLE_W-1:0] res_sample,
  input logic [CHAN_W-1:0]   res_chan,
  input logic [SEQ_W-1:0]    res_seq,
  input logic                repeat_step
);
  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && avg_shift == '0 && !repeat_step) |=>
      (res_valid && res_sample == $past(smp_data) &&
       res_chan == $past(smp_chan) && res_seq == $past(smp_seq)));

  a_r8_single_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && avg_shift == '0 && !repeat_step) |=> !repeat_step);

  a_r8_repeat_low_on_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !repeat_step);

  a_r3_result_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(smp_valid));

  a_r10_idle_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (repeat_step && !smp_valid) |=> (repeat_step && !res_valid));

endmodule

bind sample_averager sample_averager_chk #(
  .SAMPLE_W(SAMPLE_W), .SHIFT_W(SHIFT_W), .CHAN_W(CHAN_W), .SEQ_W(SEQ_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .avg_shift(avg_shift), .smp_valid(smp_valid),
  .smp_data(smp_data), .smp_chan(smp_chan), .smp_seq(smp_seq),
  .res_valid(res_valid), .res_sample(res_sample), .res_chan(res_chan),
  .res_seq(res_seq), .repeat_step(repeat_step)
);

// File: tb/sample_averager_tb_top.sv
module sample_averager_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  avg_shift = 3'd0;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic [3:0]  smp_chan = '0;
  logic [1:0]  smp_seq = '0;
  logic        res_valid;
  logic [11:0] res_sample;
  logic [3:0]  res_chan;
  logic [1:0]  res_seq;
  logic        repeat_step;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    finished = 1'b0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_averager dut_i (
    .clk(clk), .rst_n(rst_n), .avg_shift(avg_shift), .smp_valid(smp_valid),
    .smp_data(smp_data), .smp_chan(smp_chan), .smp_seq(smp_seq),
    .res_valid(res_valid), .res_sample(res_sample), .res_chan(res_chan),
    .res_seq(res_seq), .repeat_step(repeat_step)
  );

  // Behavioural reference model
  int m_acc, m_n, m_k, m_chan, m_seq, m_os, m_oc, m_oq;
  bit m_busy, m_ov;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_ov = 0; m_acc = 0; m_n = 0; m_k = 0;
      m_chan = 0; m_seq = 0; m_os = 0; m_oc = 0; m_oq = 0;
    end else begin
      m_ov = 0;
      if (smp_valid) begin
        if (!m_busy || int'(smp_chan) != m_chan || int'(smp_seq) != m_seq) begin
          m_k = (avg_shift > 3'd6) ? 6 : int'(avg_shift);
          m_acc = 0; m_n = 0;
          m_chan = int'(smp_chan); m_seq = int'(smp_seq);
        end
        m_acc += int'(smp_data);
        m_n++;
        if (m_n == (1 << m_k)) begin
          m_ov = 1; m_os = m_acc >> m_k; m_oc = m_chan; m_oq = m_seq;
          m_busy = 0;
        end else begin
          m_busy = 1;
        end
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(cur_req, "model res_valid", int'(res_valid), int'(m_ov));
      check(cur_req, "model repeat_step", int'(repeat_step), int'(m_busy));
      if (m_ov) begin
        check(cur_req, "model res_sample", int'(res_sample), m_os);
        check("R9", "model res_chan", int'(res_chan), m_oc);
        check("R9", "model res_seq", int'(res_seq), m_oq);
      end
    end
  end

  task automatic send(input int d, input int ch, input int sq);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 12'(d); smp_chan = 4'(ch); smp_seq = 2'(sq);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "res_valid in reset", int'(res_valid), 0);
    check("R1", "repeat_step in reset", int'(repeat_step), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "res_valid after reset", int'(res_valid), 0);
    check("R1", "repeat_step after reset", int'(repeat_step), 0);

    // R2 and R9: pass-through
    cur_req = "R2";
    avg_shift = 3'd0;
    send(12'h123, 3, 1);
    check("R2", "pass sample", int'(res_sample), 12'h123);
    check("R2", "pass valid", int'(res_valid), 1);
    check("R9", "pass chan", int'(res_chan), 3);
    check("R9", "pass seq", int'(res_seq), 1);
    check("R2", "pass no repeat", int'(repeat_step), 0);

    // R3 and R8: shift 2
    cur_req = "R3";
    avg_shift = 3'd2;
    send(10, 1, 0);
    check("R8", "repeat after first", int'(repeat_step), 1);
    check("R3", "no early result", int'(res_valid), 0);
    send(20, 1, 0);
    send(30, 1, 0);
    send(41, 1, 0);
    check("R3", "avg of four", int'(res_sample), 25);
    check("R3", "valid on fourth", int'(res_valid), 1);
    check("R8", "repeat low at result", int'(repeat_step), 0);
    @(negedge clk);
    check("R3", "single pulse", int'(res_valid), 0);

    // R4: full scale, shift 6
    cur_req = "R4";
    avg_shift = 3'd6;
    for (int i = 0; i < 64; i++) send(4095, 2, 2);
    check("R4", "full scale avg", int'(res_sample), 4095);
    check("R4", "full scale valid", int'(res_valid), 1);

    // R5: shift 7 acts as 6 (0..63 averages to 31)
    cur_req = "R5";
    avg_shift = 3'd7;
    for (int i = 0; i < 32; i++) send(i, 4, 0);
    check("R5", "no result after 32", int'(res_valid), 0);
    check("R5", "still pending", int'(repeat_step), 1);
    for (int i = 32; i < 64; i++) send(i, 4, 0);
    check("R5", "result after 64", int'(res_sample), 31);
    check("R5", "valid after 64", int'(res_valid), 1);

    // R6: setting latched at first sample
    cur_req = "R6";
    avg_shift = 3'd1;
    send(8, 5, 1);
    avg_shift = 3'd3;
    send(12, 5, 1);
    check("R6", "old shift kept", int'(res_sample), 10);
    check("R6", "old shift valid", int'(res_valid), 1);
    send(7, 5, 1);
    send(7, 5, 1);
    check("R6", "new shift applies", int'(res_valid), 0);
    for (int i = 0; i < 6; i++) send(7, 5, 1);
    check("R6", "new shift result", int'(res_sample), 7);

    // R7: tag change restarts
    cur_req = "R7";
    avg_shift = 3'd2;
    send(100, 1, 0);
    send(100, 1, 0);
    for (int i = 0; i < 3; i++) send(8, 2, 0);
    check("R7", "restarted run pending", int'(res_valid), 0);
    send(8, 2, 0);
    check("R7", "restart avg", int'(res_sample), 8);
    check("R7", "restart chan", int'(res_chan), 2);

    // R10: idle gap
    cur_req = "R10";
    avg_shift = 3'd1;
    send(50, 6, 3);
    repeat (5) @(negedge clk);
    check("R10", "pending across gap", int'(repeat_step), 1);
    check("R10", "no result in gap", int'(res_valid), 0);
    send(52, 6, 3);
    check("R10", "avg after gap", int'(res_sample), 51);

    // Mixed random traffic against the model
    cur_req = "R3";
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (($urandom % 60) == 0) avg_shift = 3'($urandom % 8);
      smp_valid = (($urandom % 10) < 7);
      smp_data  = 12'($urandom);
      if (($urandom % 40) == 0) smp_chan = 4'(1 + ($urandom % 2));
      if (($urandom % 80) == 0) smp_seq = 2'($urandom % 4);
    end
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule